// File: doc/BRIEF.md
# Segmented Instruction Prefetch Unit

This block is the fetch front end of a small pipelined processor that addresses memory through a segment and an offset. It keeps a 16-bit code segment and a 16-bit instruction offset. From these it forms a 20-bit physical byte address: the segment moved up by four bit places, plus the offset, with the carry out of bit 19 thrown away. It sends single-byte read requests on a simple in-order memory port and places each returned opcode byte in a six-entry first-in first-out queue. The execution side takes bytes from that queue through a valid/ready port.

Fetching runs on its own. A new request goes out whenever the queue still has room once the requests already on their way are counted. The requests do not wait for instruction boundaries, so part of an instruction can already be queued while the rest is still being fetched. A flush input, raised for one cycle on a taken branch, empties the queue and loads a new segment and offset. Any response that belongs to a request made before the flush is thrown away when it comes back. Fetching then starts again at the new target.

Top module: `seg_prefetch_unit`

## Requirements
- R1: While `mem_rd` is high, `mem_addr` equals (segment × 16 + offset) mod 2^20 for the current segment and offset.
- R2: Synchronous active-low reset empties the queue, so `out_valid` is 0. The first fetch after reset is made from segment 0xFFFF, offset 0x0000, which is address 0xFFFF0.
- R3: Queued bytes plus requests in flight never exceed 6. With the consumer stalled, exactly 6 requests are accepted and then `mem_rd` stays low.
- R4: Bytes leave on `out_byte` in the order they were requested. The offset goes up by one for each accepted request and wraps from 0xFFFF to 0x0000 inside the same segment.
- R5: A cycle with `flush` high empties the queue. In the next cycle `out_valid` is 0, and the bytes that follow come from `flush_cs`:`flush_ip`.
- R6: A response to a request that was accepted before a flush is dropped and never reaches `out_byte`.
- R7: No request is raised in a cycle with `flush` high. While `mem_rd` is high and `mem_ready` is low, `mem_rd` stays high and `mem_addr` holds its value until a flush.
- R8: A pop happens when `out_valid` and `out_ready` are both high. A push and a pop can happen in the same cycle, including when the queue is full, so a consumer that never stalls takes one byte per cycle. While `out_ready` is low, `out_byte` holds.
- R9: Freeing one queue entry lets a new fetch go out, even though only part of the next instruction then fits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| flush | input | 1 | Branch taken: empty the queue and load the new target |
| flush_cs | input | 16 | New code segment, loaded on flush |
| flush_ip | input | 16 | New instruction offset, loaded on flush |
| mem_rd | output | 1 | Read request strobe |
| mem_addr | output | 20 | Physical byte address of the request |
| mem_ready | input | 1 | Memory accepts the request in this cycle |
| mem_rvalid | input | 1 | Read data valid; responses return in request order |
| mem_rdata | input | 8 | Returned opcode byte |
| out_valid | output | 1 | Queue holds at least one byte |
| out_ready | input | 1 | Consumer takes the head byte |
| out_byte | output | 8 | Head byte of the queue |

## Verification
The bench targets address wrap in both of its forms, and each has its own failure. If the offset carried into the segment, the offset step 0xFFFF to 0x0000 would fetch from the next segment instead of going back to the segment base. If the top carry were kept, a sum above 0xFFFFF would give a wrong 20-bit address. It flushes while a response is still on its way: a design that pushed such a stale byte would hand the consumer an opcode from the old path ahead of the branch target. It stalls the consumer to fill the queue and then frees one entry. A design that forgot the in-flight requests would accept more than six requests and lose bytes, and one that waited for more room would fetch too late. A final stretch with the consumer never stalling shows whether push and pop in the same cycle keep one byte per cycle flowing.

// File: rtl/pfu_pkg.sv
// Package: constants shared by the segmented prefetch unit.
// Assumes: the segment is moved up by a fixed number of bit places before the offset is added.
package pfu_pkg;
    localparam int unsigned PFU_SEG_SHIFT = 4;
    localparam int unsigned PFU_QUEUE_DEPTH = 6;

    // Width of a counter that has to reach the value depth.
    function automatic int unsigned pfu_cnt_w(input int unsigned depth);
        return $clog2(depth + 1);
    endfunction
endpackage

// File: rtl/pfu_addr_gen.sv
// Module: pfu_addr_gen
// Turns segment:offset into a physical address. The segment moves up by
// SHIFT bit places and the offset is added. The sum is cut to PA_W bits,
// so any carry out of the top bit is lost.
// Assumes: PA_W is no wider than SEG_W + SHIFT.
module pfu_addr_gen #(
    parameter int unsigned SEG_W = 16,
    parameter int unsigned OFF_W = 16,
    parameter int unsigned PA_W  = 20,
    parameter int unsigned SHIFT = pfu_pkg::PFU_SEG_SHIFT
) (
    input  logic [SEG_W-1:0] seg,
    input  logic [OFF_W-1:0] off,
    output logic [PA_W-1:0]  pa
);
    localparam int unsigned BASE_W = SEG_W + SHIFT;

    logic [BASE_W-1:0] base;

    // Moved-up segment base.
    assign base = {seg, {SHIFT{1'b0}}};
    // Sum taken modulo 2^PA_W.
    assign pa = PA_W'(base) + PA_W'(off);
endmodule

// File: rtl/pfu_byte_fifo.sv
// Module: pfu_byte_fifo
// Circular byte queue of DEPTH entries. Push and pop may happen in the same
// cycle, also when the queue is full. Clear empties it in one cycle and
// wins over push and pop in that cycle.
// Assumes: the caller pushes only when a slot is reserved. A push into a full
// queue without a pop is dropped.
module pfu_byte_fifo #(
    parameter int unsigned DEPTH = pfu_pkg::PFU_QUEUE_DEPTH,
    parameter int unsigned W     = 8,
    localparam int unsigned CNT_W = pfu_pkg::pfu_cnt_w(DEPTH),
    localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             push,
    input  logic [W-1:0]     wdata,
    input  logic             pop,
    output logic [W-1:0]     rdata,
    output logic             not_empty,
    output logic [CNT_W-1:0] count
);
    logic [W-1:0]     store [DEPTH];
    logic [PTR_W-1:0] wr_ptr, rd_ptr;
    logic [CNT_W-1:0] cnt;
    logic             do_pop, do_push;

    // Step a pointer forward, wrapping at DEPTH.
    function automatic logic [PTR_W-1:0] ptr_next(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
    endfunction

    // Work out which transfers take place this cycle.
    always_comb begin
        do_pop  = pop && (cnt != '0);
        do_push = push && ((cnt < CNT_W'(DEPTH)) || do_pop);
    end

    // Write the byte being pushed into its slot.
    always_ff @(posedge clk) begin
        if (do_push && !clear) begin
            store[wr_ptr] <= wdata;
        end
    end

    // Update the pointers and the fill count.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            cnt    <= '0;
        end else begin
            if (do_push) wr_ptr <= ptr_next(wr_ptr);
            if (do_pop)  rd_ptr <= ptr_next(rd_ptr);
            cnt <= cnt + CNT_W'(do_push) - CNT_W'(do_pop);
        end
    end

    assign rdata     = store[rd_ptr];
    assign not_empty = (cnt != '0);
    assign count     = cnt;
endmodule

// File: rtl/pfu_fetch_ctrl.sv
// Module: pfu_fetch_ctrl
// Holds the segment and offset registers and decides when a read goes out.
// It keeps two counters of requests in flight. "live" requests will be
// pushed into the queue when they return. "stale" requests were made before
// a flush and are dropped when they return.
// Assumes: memory returns responses in request order, and never more
// responses than requests.
module pfu_fetch_ctrl #(
    parameter int unsigned SEG_W   = 16,
    parameter int unsigned OFF_W   = 16,
    parameter int unsigned DEPTH   = pfu_pkg::PFU_QUEUE_DEPTH,
    parameter logic [SEG_W-1:0] RST_SEG = '1,
    parameter logic [OFF_W-1:0] RST_OFF = '0,
    localparam int unsigned CNT_W = pfu_pkg::pfu_cnt_w(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    input  logic [SEG_W-1:0] flush_seg,
    input  logic [OFF_W-1:0] flush_off,
    input  logic [CNT_W-1:0] fifo_count,
    input  logic             mem_ready,
    input  logic             mem_rvalid,
    output logic             mem_rd,
    output logic [SEG_W-1:0] seg,
    output logic [OFF_W-1:0] off,
    output logic             push
);
    localparam int unsigned SUM_W = CNT_W + 1;

    logic [CNT_W-1:0] live, stale;
    logic [SUM_W-1:0] used, inflight;
    logic             issue, resp_keep, resp_drop;

    // Room check: queued bytes plus live requests, and the total in flight.
    always_comb begin
        used      = SUM_W'(fifo_count) + SUM_W'(live);
        inflight  = SUM_W'(live) + SUM_W'(stale);
        mem_rd    = !flush && (used < SUM_W'(DEPTH)) && (inflight < SUM_W'(DEPTH));
        issue     = mem_rd && mem_ready;
        resp_drop = mem_rvalid && (stale != '0);
        resp_keep = mem_rvalid && (stale == '0);
        push      = resp_keep && !flush;
    end

    // Segment and offset: load on flush, step on each accepted request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seg <= RST_SEG;
            off <= RST_OFF;
        end else if (flush) begin
            seg <= flush_seg;
            off <= flush_off;
        end else if (issue) begin
            off <= off + OFF_W'(1);
        end
    end

    // In-flight counters: on a flush, every outstanding request becomes stale.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            live  <= '0;
            stale <= '0;
        end else if (flush) begin
            live  <= '0;
            stale <= stale + live - CNT_W'(mem_rvalid);
        end else begin
            live  <= live + CNT_W'(issue) - CNT_W'(resp_keep);
            stale <= stale - CNT_W'(resp_drop);
        end
    end
endmodule

// File: rtl/seg_prefetch_unit.sv
// Module: seg_prefetch_unit (top)
// Prefetches opcode bytes from segment:offset into a byte queue and serves
// them on a valid/ready port. A flush empties the queue and moves fetching
// to a new target.
// Assumes: in-order single-byte memory responses; flush lasts one cycle per branch.
module seg_prefetch_unit #(
    parameter int unsigned SEG_W  = 16,
    parameter int unsigned OFF_W  = 16,
    parameter int unsigned PA_W   = 20,
    parameter int unsigned DATA_W = 8,
    parameter int unsigned DEPTH  = pfu_pkg::PFU_QUEUE_DEPTH,
    parameter logic [SEG_W-1:0] RST_SEG = 16'hFFFF,
    parameter logic [OFF_W-1:0] RST_OFF = 16'h0000,
    localparam int unsigned CNT_W = pfu_pkg::pfu_cnt_w(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush,
    input  logic [SEG_W-1:0]  flush_cs,
    input  logic [OFF_W-1:0]  flush_ip,
    output logic              mem_rd,
    output logic [PA_W-1:0]   mem_addr,
    input  logic              mem_ready,
    input  logic              mem_rvalid,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [DATA_W-1:0] out_byte
);
    logic [SEG_W-1:0] seg;
    logic [OFF_W-1:0] off;
    logic [CNT_W-1:0] fifo_count;
    logic             push;

    // Fetch sequencing and the segment/offset registers.
    pfu_fetch_ctrl #(
        .SEG_W(SEG_W), .OFF_W(OFF_W), .DEPTH(DEPTH),
        .RST_SEG(RST_SEG), .RST_OFF(RST_OFF)
    ) u_ctrl (
        .clk(clk), .rst_n(rst_n), .flush(flush),
        .flush_seg(flush_cs), .flush_off(flush_ip),
        .fifo_count(fifo_count), .mem_ready(mem_ready), .mem_rvalid(mem_rvalid),
        .mem_rd(mem_rd), .seg(seg), .off(off), .push(push)
    );

    // Physical address generation.
    pfu_addr_gen #(
        .SEG_W(SEG_W), .OFF_W(OFF_W), .PA_W(PA_W), .SHIFT(pfu_pkg::PFU_SEG_SHIFT)
    ) u_addr (
        .seg(seg), .off(off), .pa(mem_addr)
    );

    // Opcode byte queue.
    pfu_byte_fifo #(
        .DEPTH(DEPTH), .W(DATA_W)
    ) u_fifo (
        .clk(clk), .rst_n(rst_n), .clear(flush),
        .push(push), .wdata(mem_rdata), .pop(out_ready),
        .rdata(out_byte), .not_empty(out_valid), .count(fifo_count)
    );
endmodule

// File: rtl/pfu_checker.sv
// Module: pfu_checker
// Protocol and capacity properties of seg_prefetch_unit, attached by bind.
// Assumes: it is bound to the top module, which has the internal fifo_count.
module pfu_checker #(
    parameter int unsigned PA_W   = 20,
    parameter int unsigned DATA_W = 8,
    parameter int unsigned DEPTH  = 6,
    parameter int unsigned CNT_W  = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              flush,
    input logic              mem_rd,
    input logic              mem_ready,
    input logic [PA_W-1:0]   mem_addr,
    input logic              out_valid,
    input logic              out_ready,
    input logic [DATA_W-1:0] out_byte,
    input logic [CNT_W-1:0]  fifo_count
);
    // R2: the cycle after a reset cycle shows an empty queue.
    assert_reset_empty_R2: assert property (@(posedge clk)
        !rst_n |=> !out_valid);

    // R3: the queue never holds more than DEPTH bytes.
    assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_count <= CNT_W'(DEPTH));

    // R5: a flush leaves the queue empty.
    assert_flush_empties_R5: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> !out_valid);

    // R7: no request during a flush.
    assert_no_fetch_on_flush_R7: assert property (@(posedge clk) disable iff (!rst_n)
        flush |-> !mem_rd);

    // R7: a request that is not accepted holds its address.
    assert_hold_request_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd && !mem_ready) |=> (flush || (mem_rd && $stable(mem_addr))));

    // R8: a head byte that is not taken stays in place.
    assert_out_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready && !flush) |=> (out_valid && $stable(out_byte)));
endmodule

bind seg_prefetch_unit pfu_checker #(
    .PA_W(PA_W), .DATA_W(DATA_W), .DEPTH(DEPTH), .CNT_W(CNT_W)
) u_pfu_checker (
    .clk(clk), .rst_n(rst_n), .flush(flush), .mem_rd(mem_rd),
    .mem_ready(mem_ready), .mem_addr(mem_addr), .out_valid(out_valid),
    .out_ready(out_ready), .out_byte(out_byte), .fifo_count(fifo_count)
);

// File: tb/test_seg_prefetch_unit.sv
`timescale 1ns/100ps
// Bench for seg_prefetch_unit. A memory model answers each accepted request
// two cycles later. A monitor checks every popped byte against the address
// expected for it.
module test_seg_prefetch_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        flush = 1'b0;
    logic [15:0] flush_cs = '0, flush_ip = '0;
    logic        mem_rd;
    logic [19:0] mem_addr;
    logic        mem_ready = 1'b1;
    logic        mem_rvalid = 1'b0;
    logic [7:0]  mem_rdata = '0;
    logic        out_valid;
    logic        out_ready = 1'b0;
    logic [7:0]  out_byte;

    int errors = 0, checks = 0;
    int acc_cnt = 0, pop_cnt = 0;
    bit done = 1'b0;
    logic [15:0] exp_cs = 16'hFFFF, exp_ip = 16'h0000;
    logic s0_v = 0, s1_v = 0;
    logic [19:0] s0_a = '0, s1_a = '0;

    always #4 clk = ~clk;

    seg_prefetch_unit i_seg_prefetch_unit (
        .clk(clk), .rst_n(rst_n), .flush(flush), .flush_cs(flush_cs), .flush_ip(flush_ip),
        .mem_rd(mem_rd), .mem_addr(mem_addr), .mem_ready(mem_ready),
        .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
        .out_valid(out_valid), .out_ready(out_ready), .out_byte(out_byte)
    );

    function automatic logic [7:0] mdata(input logic [19:0] a);
        return a[7:0] ^ a[15:8] ^ {a[19:16], a[19:16]} ^ 8'h5A;
    endfunction

    function automatic logic [19:0] phys(input logic [15:0] s, input logic [15:0] o);
        return {s, 4'h0} + {4'h0, o};
    endfunction

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Memory model: sees requests before the edge, answers two edges later.
    always begin
        @(negedge clk); #2;
        if (!rst_n) begin
            s0_v = 0; s1_v = 0; mem_rvalid = 0;
        end else begin
            mem_rvalid = s1_v;
            mem_rdata  = mdata(s1_a);
            s1_v = s0_v; s1_a = s0_a;
            s0_v = mem_rd && mem_ready;
            s0_a = mem_addr;
            if (s0_v) acc_cnt++;
        end
    end

    // Consumer monitor: every popped byte must match the next expected address (R4).
    always begin
        @(negedge clk); #3;
        if (rst_n && !flush && out_valid && out_ready) begin
            check(out_byte == mdata(phys(exp_cs, exp_ip)), "R4 byte order",
                  {24'h0, out_byte}, {24'h0, mdata(phys(exp_cs, exp_ip))});
            exp_ip = exp_ip + 16'd1;
            pop_cnt++;
        end
    end

    task automatic step();
        @(negedge clk); #1;
    endtask

    task automatic do_flush(input logic [15:0] cs, input logic [15:0] ip);
        step();
        flush = 1'b1; flush_cs = cs; flush_ip = ip;
        exp_cs = cs; exp_ip = ip;
        step();
        flush = 1'b0;
        #0.5;
    endtask

    // Table: cs[63:48], ip[47:32], expected first address [27:8], bytes [7:0]
    localparam logic [63:0] VEC [6] = '{
        {16'h1234, 16'h0010, 4'h0, 20'h12350, 8'd10},
        {16'hF000, 16'hFFFE, 4'h0, 20'hFFFFE, 8'd8},
        {16'hFFFF, 16'h0020, 4'h0, 20'h00010, 8'd7},
        {16'h0000, 16'h0000, 4'h0, 20'h00000, 8'd12},
        {16'hABCD, 16'h1234, 4'h0, 20'hACF04, 8'd6},
        {16'h0FFF, 16'hFFFF, 4'h0, 20'h1FFEF, 8'd9}
    };

    initial begin
        int snap_acc, snap_pop, cyc;
        logic [19:0] hold_a;
        // Reset state (R2)
        repeat (3) step();
        #0.5;
        check(out_valid == 1'b0, "R2 empty during reset", {31'h0, out_valid}, 32'h0);
        step(); rst_n = 1'b1; #0.5;
        check(mem_rd == 1'b1, "R2 fetch after reset", {31'h0, mem_rd}, 32'h1);
        check(mem_addr == 20'hFFFF0, "R2 reset address", {12'h0, mem_addr}, 32'hFFFF0);
        check(out_valid == 1'b0, "R2 empty after reset", {31'h0, out_valid}, 32'h0);

        // Table loop: flush to each target, consume with stalls (R1, R4, R5, R6)
        for (int i = 0; i < 6; i++) begin
            do_flush(VEC[i][63:48], VEC[i][47:32]);
            check(out_valid == 1'b0, "R5 empty after flush", {31'h0, out_valid}, 32'h0);
            check(mem_rd && mem_addr == VEC[i][27:8], "R1 target address",
                  {12'h0, mem_addr}, {12'h0, VEC[i][27:8]});
            snap_pop = pop_cnt;
            cyc = 0;
            while ((pop_cnt - snap_pop) < int'(VEC[i][7:0]) && cyc < 500) begin
                mem_ready = (i % 2 == 1) ? (cyc % 3 != 0) : 1'b1;
                out_ready = (i % 2 == 0) ? (cyc % 2 == 0) : 1'b1;
                step();
                cyc++;
            end
            check(cyc < 500, "R4 bytes delivered", cyc, VEC[i][7:0]);
        end
        mem_ready = 1'b1; out_ready = 1'b0;

        // Capacity with stalled consumer (R3), then refill on one free slot (R9)
        do_flush(16'h2000, 16'h0000);
        snap_acc = acc_cnt;
        repeat (20) step();
        #0.5;
        check(acc_cnt - snap_acc == 6, "R3 six requests", acc_cnt - snap_acc, 6);
        check(mem_rd == 1'b0, "R3 fetch stops", {31'h0, mem_rd}, 32'h0);
        out_ready = 1'b1; step(); out_ready = 1'b0;
        repeat (4) step();
        #0.5;
        check(acc_cnt - snap_acc == 7, "R9 refill one slot", acc_cnt - snap_acc, 7);

        // Full queue, consumer never stalls: one byte per cycle (R8)
        repeat (6) step();
        snap_pop = pop_cnt;
        out_ready = 1'b1;
        repeat (20) step();
        out_ready = 1'b0;
        step();
        check(pop_cnt - snap_pop >= 18, "R8 back-to-back pops", pop_cnt - snap_pop, 20);

        // Stale response after a flush is dropped (R6)
        do_flush(16'h3000, 16'h0100);
        flush = 1'b1; flush_cs = 16'h4000; flush_ip = 16'h0200;
        exp_cs = 16'h4000; exp_ip = 16'h0200;
        step(); flush = 1'b0;
        cyc = 0;
        while (!out_valid && cyc < 50) begin step(); cyc++; end
        #0.5;
        check(out_byte == mdata(20'h40200), "R6 stale byte dropped",
              {24'h0, out_byte}, {24'h0, mdata(20'h40200)});

        // Request held while memory is not ready (R7)
        mem_ready = 1'b0;
        do_flush(16'h5000, 16'h0003);
        hold_a = mem_addr;
        snap_acc = acc_cnt;
        repeat (5) step();
        #0.5;
        check(mem_rd && mem_addr == hold_a && hold_a == 20'h50003, "R7 held address",
              {12'h0, mem_addr}, 32'h50003);
        check(acc_cnt == snap_acc, "R7 nothing accepted", acc_cnt - snap_acc, 0);
        mem_ready = 1'b1; out_ready = 1'b1;
        repeat (10) step();
        check(pop_cnt > 0, "R7 resumes", pop_cnt, 1);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule